// File: doc/BRIEF.md
# MSI Doorbell Capture Interrupt Controller

This block sits behind the inbound side of a PCIe-style link. Each memory write that reaches the controller is compared against a 64-bit doorbell address held in two software registers. If the address matches, the write's 32-bit payload is taken as a vector index. The index selects a bank, `index >> 5`, and a bit in that bank, `index & 31`. If the vector is enabled, the matching status bit is latched. Vectors come in banks of 32, and the bank count is a parameter (default 8, giving 256 vectors).

Software uses a flat 32-bit register port with a 12-bit byte offset. Through it, software:
- programs the doorbell address;
- turns vectors on and off by a read-modify-write of the bank enable word;
- hides vectors from the interrupt line with a mask word;
- services pending vectors by writing ones to the status word.

A single level interrupt reports any pending vector that is not masked. A sticky error flag records inbound writes that were thrown away because the address missed or the index was out of range.

The inbound port uses a valid/ready handshake, and `in_ready` is tied high. The controller takes one write in every cycle where `in_valid` is 1, so the upstream side never sees back-pressure and never has to hold a beat.

Top module: `msi_doorbell_ctrl`

## Requirements
- R1: After reset, every register reads 0x00000000, `irq_out` is 0 and `err_flag` is 0.
- R2: Offset 0x820 holds the low 32 bits of the doorbell address and offset 0x824 holds the high 32 bits. Both are read/write.
- R3: Bank n has three registers: enable at 0x828+12n, mask at 0x82C+12n and status at 0x830+12n. Enable and mask are read/write. Any other offset, including an unaligned one, reads as zero, and writes to it change nothing.
- R4: An accepted inbound write sets status bit `data & 31` of bank `data >> 5` when three conditions hold: its 64-bit address equals the doorbell address, its data is below 32×banks, and that vector's enable bit is 1. The bit is readable from the first cycle after acceptance.
- R5: A write that matches the doorbell for a disabled vector changes no status bit and does not raise `err_flag`.
- R6: A write to any other address, or one whose data is 32×banks or larger, changes no status bit and sets `err_flag`. The flag then stays 1 until reset.
- R7: Writing the status register clears each bit written as 1 and leaves each bit written as 0 unchanged. Software can never set a status bit.
- R8: If an inbound set and a software clear hit the same status bit in the same cycle, the bit ends up set.
- R9: `irq_out` is 1 exactly while some bank has a status bit at 1 whose mask bit is 0.
- R10: `in_ready` is 1 in every cycle, and each cycle with `in_valid` at 1 is one accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_addr | input | 12 | Register byte offset, used for both reads and writes |
| csr_wen | input | 1 | Register write strobe |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Read data for `csr_addr`, combinational |
| in_valid | input | 1 | Inbound write present |
| in_ready | output | 1 | Inbound write accepted; always 1 |
| in_addr | input | 64 | Inbound write address |
| in_data | input | 32 | Inbound write payload (vector index) |
| irq_out | output | 1 | Level interrupt: some unmasked vector is pending |
| err_flag | output | 1 | Sticky flag for discarded inbound writes |

## Verification
The assertions assume three things about the inputs:
- `rst_n` is low at the first clock edge, so every `$past` term starts from a reset state.
- Register and inbound inputs change only away from the rising edge.
- An inbound beat and a register write may occur in the same cycle.

The stimulus drives every input on the falling edge and holds `rst_n` low for several cycles at the start. It deliberately aligns one inbound beat with a status clear on the same bit to cover the collision case. All register offsets it uses are word aligned, except for a deliberate probe of unused offsets.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int CSR_AW        = 12;
  localparam int VEC_PER_BANK  = 32;
  localparam int DB_LO_OFS     = 'h820;
  localparam int DB_HI_OFS     = 'h824;
  localparam int BANK0_OFS     = 'h828;
  localparam int BANK_STRIDE   = 12;
  localparam int MASK_REL      = 4;
  localparam int STAT_REL      = 8;
endpackage

// File: rtl/msi_doorbell_regs.sv
module msi_doorbell_regs
  import msi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic              csr_wen,
  input  logic [31:0]       csr_wdata,
  output logic [63:0]       db_addr,
  output logic [31:0]       rd_data
);
  localparam logic [CSR_AW-1:0] LO_OFS = CSR_AW'(DB_LO_OFS);
  localparam logic [CSR_AW-1:0] HI_OFS = CSR_AW'(DB_HI_OFS);

  logic [31:0] lo_q, hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (csr_wen) begin
      if (csr_addr == LO_OFS) lo_q <= csr_wdata;
      if (csr_addr == HI_OFS) hi_q <= csr_wdata;
    end
  end

  assign db_addr = {hi_q, lo_q};

  always_comb begin
    rd_data = '0;
    if (csr_addr == LO_OFS) rd_data = lo_q;
    if (csr_addr == HI_OFS) rd_data = hi_q;
  end

  // R2: a write to the low word is visible in the doorbell address next cycle
  a_r2_lo_takes_write: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wen && csr_addr == LO_OFS) |=> (db_addr[31:0] == $past(csr_wdata)));
  // R2: a write to the high word is visible in the doorbell address next cycle
  a_r2_hi_takes_write: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wen && csr_addr == HI_OFS) |=> (db_addr[63:32] == $past(csr_wdata)));
endmodule

// File: rtl/msi_inbound_match.sv
module msi_inbound_match
  import msi_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int NUM_VEC  = NUM_BANKS * VEC_PER_BANK,
  localparam int VEC_W    = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [63:0]        in_addr,
  input  logic [31:0]        in_data,
  input  logic [63:0]        db_addr,
  output logic [NUM_VEC-1:0] set_vec,
  output logic               err_flag
);
  logic             addr_hit;
  logic             idx_ok;
  logic             take;
  logic             bad;
  logic [VEC_W-1:0] vec_idx;
  logic             err_q;

  assign addr_hit = (in_addr == db_addr);
  assign idx_ok   = (in_data < 32'(NUM_VEC));
  assign take     = in_valid && addr_hit && idx_ok;
  assign bad      = in_valid && !(addr_hit && idx_ok);
  assign vec_idx  = in_data[VEC_W-1:0];
  assign set_vec  = take ? (NUM_VEC'(1) << vec_idx) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) err_q <= 1'b0;
    else if (bad) err_q <= 1'b1;
  end

  assign err_flag = err_q;

  // R4: at most one vector is requested per accepted beat
  a_r4_single_vector: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_vec));
  // R6: once raised the error flag holds until reset
  a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
  // R6: the flag only rises after an inbound beat
  a_r6_err_needs_beat: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_flag) |-> $past(in_valid));
  // R6: a set request never comes from a beat that missed the doorbell
  a_r6_no_set_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    (in_addr != db_addr) |-> (set_vec == '0));
endmodule

// File: rtl/msi_vector_bank.sv
module msi_vector_bank
  import msi_pkg::*;
#(
  parameter int BANK_IDX = 0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [CSR_AW-1:0]       csr_addr,
  input  logic                    csr_wen,
  input  logic [31:0]             csr_wdata,
  input  logic [VEC_PER_BANK-1:0] set_req,
  output logic [31:0]             rd_data,
  output logic                    pend
);
  localparam int                BASE     = BANK0_OFS + BANK_IDX * BANK_STRIDE;
  localparam logic [CSR_AW-1:0] EN_OFS   = CSR_AW'(BASE);
  localparam logic [CSR_AW-1:0] MASK_OFS = CSR_AW'(BASE + MASK_REL);
  localparam logic [CSR_AW-1:0] STAT_OFS = CSR_AW'(BASE + STAT_REL);

  logic [VEC_PER_BANK-1:0] en_q, mask_q, stat_q;
  logic [VEC_PER_BANK-1:0] set_eff, clr_bits;

  assign set_eff  = set_req & en_q;
  assign clr_bits = (csr_wen && csr_addr == STAT_OFS) ? csr_wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= '0;
      mask_q <= '0;
      stat_q <= '0;
    end else begin
      if (csr_wen && csr_addr == EN_OFS)   en_q   <= csr_wdata;
      if (csr_wen && csr_addr == MASK_OFS) mask_q <= csr_wdata;
      stat_q <= (stat_q & ~clr_bits) | set_eff;
    end
  end

  always_comb begin
    rd_data = '0;
    if (csr_addr == EN_OFS)   rd_data = en_q;
    if (csr_addr == MASK_OFS) rd_data = mask_q;
    if (csr_addr == STAT_OFS) rd_data = stat_q;
  end

  assign pend = |(stat_q & ~mask_q);

  // R4: a status bit only rises for an enabled vector that was requested
  a_r4_rise_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 ((stat_q & ~$past(stat_q) & ~$past(set_req & en_q)) == '0));
  // R5: a request for a disabled vector never sets its bit
  a_r5_disabled_stays: assert property (@(posedge clk) disable iff (!rst_n)
    ##1 ((stat_q & ~$past(stat_q) & ~$past(en_q)) == '0));
  // R8: a granted set wins over a same-cycle clear
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_req & en_q) != '0 |=> ((stat_q & $past(set_req & en_q)) == $past(set_req & en_q)));
  // R7: bits written as 0 and not set keep their value
  a_r7_zero_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wen && csr_addr == STAT_OFS) |=>
      (((stat_q ^ $past(stat_q)) & ~$past(csr_wdata) & ~$past(set_req & en_q)) == '0));
endmodule

// File: rtl/msi_doorbell_ctrl.sv
module msi_doorbell_ctrl
  import msi_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  localparam int NUM_VEC  = NUM_BANKS * VEC_PER_BANK
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CSR_AW-1:0] csr_addr,
  input  logic              csr_wen,
  input  logic [31:0]       csr_wdata,
  output logic [31:0]       csr_rdata,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [63:0]       in_addr,
  input  logic [31:0]       in_data,
  output logic              irq_out,
  output logic              err_flag
);
  logic [63:0]        db_addr;
  logic [31:0]        db_rd;
  logic [NUM_VEC-1:0] set_vec;
  logic [31:0]        bank_rd [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_pend;

  assign in_ready = 1'b1;

  msi_doorbell_regs u_db (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wen(csr_wen),
    .csr_wdata(csr_wdata), .db_addr(db_addr), .rd_data(db_rd)
  );

  msi_inbound_match #(.NUM_BANKS(NUM_BANKS)) u_match (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid && in_ready), .in_addr(in_addr),
    .in_data(in_data), .db_addr(db_addr), .set_vec(set_vec), .err_flag(err_flag)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    msi_vector_bank #(.BANK_IDX(b)) u_bank (
      .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wen(csr_wen),
      .csr_wdata(csr_wdata), .set_req(set_vec[b*VEC_PER_BANK +: VEC_PER_BANK]),
      .rd_data(bank_rd[b]), .pend(bank_pend[b])
    );
  end

  always_comb begin
    csr_rdata = db_rd;
    for (int b = 0; b < NUM_BANKS; b++) csr_rdata = csr_rdata | bank_rd[b];
  end

  assign irq_out = |bank_pend;

  // R10: the inbound port never applies back-pressure
  a_r10_always_ready: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready);
  // R9: a fresh interrupt follows an accepted beat or a mask change
  a_r9_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> ($past(in_valid) || $past(csr_wen)));
endmodule

// File: tb/sim_msi_doorbell_ctrl.sv
module sim_msi_doorbell_ctrl;
  localparam int CLK_P = 10;
  localparam int NB    = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] csr_addr = '0;
  logic        csr_wen = 1'b0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_addr = '0;
  logic [31:0] in_data = '0;
  logic        irq_out;
  logic        err_flag;

  int checks = 0;
  int errors = 0;

  localparam logic [63:0] DB = 64'h0000_0001_FEE0_1000;

  msi_doorbell_ctrl #(.NUM_BANKS(NB)) u0 (
    .clk(clk), .rst_n(rst_n), .csr_addr(csr_addr), .csr_wen(csr_wen),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .in_valid(in_valid),
    .in_ready(in_ready), .in_addr(in_addr), .in_data(in_data),
    .irq_out(irq_out), .err_flag(err_flag)
  );

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [11:0] en_ofs(int b);   return 12'(12'h828 + 12*b); endfunction
  function automatic logic [11:0] mask_ofs(int b); return 12'(12'h82C + 12*b); endfunction
  function automatic logic [11:0] stat_ofs(int b); return 12'(12'h830 + 12*b); endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic csr_wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    csr_addr = a; csr_wdata = d; csr_wen = 1'b1;
    @(negedge clk);
    csr_wen = 1'b0;
  endtask

  task automatic csr_rd(logic [11:0] a, output logic [31:0] d);
    csr_addr = a;
    #1;
    d = csr_rdata;
  endtask

  task automatic send(logic [63:0] a, logic [31:0] d);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a; in_data = d;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    csr_rd(12'h820, v); check("R1 lo", v, 0);
    csr_rd(stat_ofs(0), v); check("R1 stat0", v, 0);
    csr_rd(en_ofs(7), v); check("R1 en7", v, 0);
    check("R1 irq", irq_out, 0);
    check("R1 err", err_flag, 0);
    check("R10 ready", in_ready, 1);
  endtask

  task automatic t_regs;
    logic [31:0] v;
    csr_wr(12'h820, DB[31:0]);
    csr_wr(12'h824, DB[63:32]);
    csr_rd(12'h820, v); check("R2 lo", v, DB[31:0]);
    csr_rd(12'h824, v); check("R2 hi", v, DB[63:32]);
    csr_wr(mask_ofs(7), 32'hA5A5_0F0F);
    csr_rd(mask_ofs(7), v); check("R3 mask7", v, 32'hA5A5_0F0F);
    csr_wr(mask_ofs(7), 32'h0);
    csr_wr(12'h888, 32'hFFFF_FFFF);
    csr_rd(12'h888, v); check("R3 unused 888", v, 0);
    csr_rd(12'h81C, v); check("R3 unused 81C", v, 0);
    csr_rd(12'h829, v); check("R3 unaligned", v, 0);
    csr_rd(en_ofs(7), v); check("R3 en7 untouched", v, 0);
  endtask

  task automatic t_set;
    logic [31:0] v;
    csr_wr(en_ofs(0), 32'h0000_0008);
    csr_wr(en_ofs(5), 32'h8000_0000);
    send(DB, 3);
    csr_rd(stat_ofs(0), v); check("R4 bank0 bit3", v, 32'h8);
    check("R9 irq on", irq_out, 1);
    send(DB, 191);
    csr_rd(stat_ofs(5), v); check("R4 bank5 bit31", v, 32'h8000_0000);
  endtask

  task automatic t_disabled;
    logic [31:0] v;
    send(DB, 4);
    csr_rd(stat_ofs(0), v); check("R5 disabled no set", v, 32'h8);
    check("R5 no err", err_flag, 0);
  endtask

  task automatic t_error;
    logic [31:0] v;
    csr_wr(en_ofs(7), 32'hFFFF_FFFF);
    send(DB, 256);
    csr_rd(stat_ofs(7), v); check("R6 range no set", v, 0);
    check("R6 err range", err_flag, 1);
    send(DB ^ 64'h1_0000_0000, 224);
    csr_rd(stat_ofs(7), v); check("R6 addr miss no set", v, 0);
    send(DB, 3);
    check("R6 err sticky", err_flag, 1);
  endtask

  task automatic t_w1c;
    logic [31:0] v;
    csr_wr(stat_ofs(0), 32'h0);
    csr_rd(stat_ofs(0), v); check("R7 zero keeps", v, 32'h8);
    csr_wr(stat_ofs(0), 32'h8);
    csr_rd(stat_ofs(0), v); check("R7 one clears", v, 0);
    csr_wr(stat_ofs(2), 32'hFFFF_FFFF);
    csr_rd(stat_ofs(2), v); check("R7 no sw set", v, 0);
    check("R9 irq bank5 still", irq_out, 1);
  endtask

  task automatic t_mask;
    csr_wr(mask_ofs(5), 32'h8000_0000);
    check("R9 masked off", irq_out, 0);
    csr_wr(mask_ofs(5), 32'h0);
    check("R9 unmasked on", irq_out, 1);
    csr_wr(stat_ofs(5), 32'h8000_0000);
    check("R9 cleared off", irq_out, 0);
  endtask

  task automatic t_collide;
    logic [31:0] v;
    @(negedge clk);
    in_valid = 1'b1; in_addr = DB; in_data = 3;
    csr_addr = stat_ofs(0); csr_wdata = 32'h8; csr_wen = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; csr_wen = 1'b0;
    csr_rd(stat_ofs(0), v); check("R8 set wins", v, 32'h8);
  endtask

  initial begin
    #(CLK_P * 100000);
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regs();
    t_set();
    t_disabled();
    t_error();
    t_w1c();
    t_mask();
    t_collide();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule